// File: doc/BRIEF.md
# Buffered Output-Compare Timer Channel

One output-compare channel attached to a free-running 16-bit up-counter. A byte-wide register bus programs the counter clock (run bit plus a power-of-two prescale code) and the channel. It also reads back the counter, the active compare value and the channel status/control byte. When the counter advances onto the active compare value, the channel raises its flag. The flag, gated by the channel enable, drives an interrupt request. An optional pin action (toggle, clear or set) happens at the same moment.

A new compare value never reaches the comparator directly. The two bus bytes are collected by a small state machine with three states. CB_IDLE means no update is in progress. CB_PARTIAL means one byte has been captured. CB_PENDING means both bytes are held and waiting. The transitions are:

- *byte write*: CB_IDLE to CB_PARTIAL, or CB_PENDING to CB_PARTIAL, which restarts the collection.
- *arm*: CB_IDLE or CB_PARTIAL to CB_PENDING, once both bytes are present.
- *transfer*: CB_PENDING to CB_IDLE on the next counter increment, which copies the held value into the active register.
- *discard*: CB_PENDING to CB_IDLE when the status/control byte is written before that increment.

Software must therefore write the compare value first and touch the status byte only after the counter has stepped. The flag is cleared with a read-then-write handshake. A match in the clearing cycle keeps the flag set, so no event is lost.

Top module: `oc_timer_channel`

## Requirements
- R1: After reset, every readable register (timer control, counter, active compare value, status/control) reads 0. The outputs irq, pin_out and pin_oe are low.
- R2: Address 0 holds the timer control: bit 3 is run, bits 2:0 are the prescale code p. While run is 1, the counter (address 1 high byte, address 2 low byte) advances once every 2^p clocks. While run is 0 it holds. A write to address 1 or 2 clears both the counter and the prescaler.
- R3: The counter wraps from 0xFFFF to 0x0000, and a compare value of 0x0000 matches on that wrap.
- R4: Addresses 4 (high byte) and 5 (low byte) read the active compare value. A completed compare write leaves the active value unchanged until the next counter increment, which transfers it.
- R5: An update is armed only after both compare bytes have been written. Writing one byte alone never changes the active value.
- R6: A write to the status/control byte (address 3) while an update is pending and before the counter increments discards the update. The old active value stays.
- R7: Status bit 7 (flag) is set on the increment that makes the counter equal the active compare value. The comparison uses the active value as it stood before any transfer in the same cycle. With an unchanged compare value, the match repeats every 65536 increments.
- R8: irq is 1 exactly while the flag and status bit 6 (interrupt enable) are both 1.
- R9: The flag clears only when a read of address 3 that sees the flag at 1 is followed by a write to address 3 with bit 7 = 0. A write without that preceding read, or with bit 7 = 1, leaves the flag set. Writing bit 7 never sets it.
- R10: When a match occurs in the same cycle as the clearing write, the flag stays 1.
- R11: Status bits 5:4 select the mode, bits 3:2 the pin action, and bits 1:0 read as 0. The value 0x50 (mode 01, action 00) is software-only compare with the interrupt enabled: pin_oe is 0 and pin_out does not change.
- R12: In mode 01 with action 01, 10 or 11, pin_oe is 1 and each match toggles, clears or sets pin_out respectively.
- R13: With p = 0, a compare write followed at once by a status/control write still updates the active value. If the increment and the status write fall in one cycle, the transfer wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for bus_sel |
| bus_rd | input | 1 | Read qualifier for bus_sel (arms the flag-clear handshake) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Channel pin level |
| pin_oe | output | 1 | Pin driven by the channel |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the flag being set by a match and cleared by the handshake write. The bench provokes this by clearing the counter two cycles before the clearing status write, with prescale 1 and a compare value of 2. The match then lands exactly on the write, and a readback of 0xC0 shows the set won.

The second pair is the pending-value transfer and the cancelling status write. The bench tests this by issuing the status write immediately behind the compare bytes at prescale 1 and reading the new value back. The opposite case is also covered: a status write with the clock stopped must leave the old value in place.

// File: rtl/oct_pkg.sv
`timescale 1ns/1ps
package oct_pkg;

    // Compare-update collection states
    typedef enum logic [1:0] {
        CB_IDLE    = 2'd0,
        CB_PARTIAL = 2'd1,
        CB_PENDING = 2'd2
    } cb_state_e;

    // Pin action field encoding
    typedef enum logic [1:0] {
        PA_NONE   = 2'b00,
        PA_TOGGLE = 2'b01,
        PA_CLEAR  = 2'b10,
        PA_SET    = 2'b11
    } pin_act_e;

    localparam logic [2:0] RA_TCTL   = 3'd0;
    localparam logic [2:0] RA_CNT_HI = 3'd1;
    localparam logic [2:0] RA_CNT_LO = 3'd2;
    localparam logic [2:0] RA_CSC    = 3'd3;
    localparam logic [2:0] RA_CMP_HI = 3'd4;
    localparam logic [2:0] RA_CMP_LO = 3'd5;

    localparam logic [1:0] MODE_OC = 2'b01;

endpackage

// File: rtl/oct_tick_gen.sv
`timescale 1ns/1ps
module oct_tick_gen #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_limit;

    always_comb begin
        div_limit = (DIV_W'(1) << ps_sel) - DIV_W'(1);
        tick      = run && (div_q == div_limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (restart || !run || tick)
            div_q <= '0;
        else
            div_q <= div_q + DIV_W'(1);
    end
endmodule

// File: rtl/oct_cmp_buffer.sv
`timescale 1ns/1ps
module oct_cmp_buffer
    import oct_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ctl_wr,
    input  logic              tick,
    output logic [CNT_W-1:0]  cmp_active,
    output cb_state_e         state
);
    cb_state_e         state_n;
    logic              got_hi, got_lo;
    logic              got_hi_n, got_lo_n;
    logic [DATA_W-1:0] hold_hi, hold_lo;
    logic              load;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CB_IDLE;
        else        state <= state_n;
    end

    // Next state
    always_comb begin
        got_hi_n = ((state == CB_PARTIAL) && got_hi) || wr_hi;
        got_lo_n = ((state == CB_PARTIAL) && got_lo) || wr_lo;
        state_n  = state;
        unique case (state)
            CB_IDLE, CB_PARTIAL: begin
                if (got_hi_n && got_lo_n)      state_n = CB_PENDING;
                else if (got_hi_n || got_lo_n) state_n = CB_PARTIAL;
            end
            CB_PENDING: begin
                if (tick)                state_n = (wr_hi || wr_lo) ? CB_PARTIAL : CB_IDLE;
                else if (ctl_wr)         state_n = CB_IDLE;
                else if (wr_hi || wr_lo) state_n = CB_PARTIAL;
            end
            default: state_n = CB_IDLE;
        endcase
    end

    // Outputs: transfer strobe
    always_comb load = (state == CB_PENDING) && tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            got_hi     <= 1'b0;
            got_lo     <= 1'b0;
            hold_hi    <= '0;
            hold_lo    <= '0;
            cmp_active <= '0;
        end else begin
            got_hi <= (state_n == CB_PARTIAL) ? got_hi_n : 1'b0;
            got_lo <= (state_n == CB_PARTIAL) ? got_lo_n : 1'b0;
            if (wr_hi) hold_hi <= wdata;
            if (wr_lo) hold_lo <= wdata;
            if (load)  cmp_active <= {hold_hi, hold_lo};
        end
    end
endmodule

// File: rtl/oct_chan_ctrl.sv
`timescale 1ns/1ps
module oct_chan_ctrl
    import oct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sc_wr,
    input  logic       sc_rd,
    input  logic [7:2] wbits,
    input  logic       match,
    output logic [7:0] sc_rdata,
    output logic       flag,
    output logic       irq,
    output logic       pin_out,
    output logic       pin_oe
);
    logic       ie;
    logic [1:0] mode;
    pin_act_e   act;
    logic       armed;
    logic       clr_ok;
    logic       pin_drive;

    always_comb begin
        clr_ok    = sc_wr && armed && !wbits[7];
        pin_drive = (mode == MODE_OC) && (act != PA_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag    <= 1'b0;
            ie      <= 1'b0;
            mode    <= 2'b00;
            act     <= PA_NONE;
            armed   <= 1'b0;
            pin_out <= 1'b0;
        end else begin
            if (match)       flag <= 1'b1;
            else if (clr_ok) flag <= 1'b0;

            if (sc_wr)              armed <= 1'b0;
            else if (sc_rd && flag) armed <= 1'b1;

            if (sc_wr) begin
                ie   <= wbits[6];
                mode <= wbits[5:4];
                act  <= pin_act_e'(wbits[3:2]);
            end

            if (match && pin_drive) begin
                unique case (act)
                    PA_TOGGLE: pin_out <= ~pin_out;
                    PA_CLEAR:  pin_out <= 1'b0;
                    PA_SET:    pin_out <= 1'b1;
                    default:   pin_out <= pin_out;
                endcase
            end
        end
    end

    always_comb begin
        sc_rdata = {flag, ie, mode, act, 2'b00};
        irq      = flag && ie;
        pin_oe   = pin_drive;
    end
endmodule

// File: rtl/oc_timer_channel.sv
`timescale 1ns/1ps
module oc_timer_channel
    import oct_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              pin_out,
    output logic              pin_oe
);
    localparam int CNT_W = 2 * DATA_W;

    logic            wr_any, rd_any;
    logic            tctl_wr, cnt_wr, sc_wr, sc_rd, cmp_hi_wr, cmp_lo_wr;
    logic            run_q;
    logic [PS_W-1:0] ps_q;
    logic            tick;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cmp_active;
    cb_state_e       cb_state;
    logic            match;
    logic            ch_flag;
    logic [7:0]      sc_rdata;

    always_comb begin
        wr_any    = bus_sel && bus_wr;
        rd_any    = bus_sel && bus_rd;
        tctl_wr   = wr_any && (bus_addr == RA_TCTL);
        cnt_wr    = wr_any && ((bus_addr == RA_CNT_HI) || (bus_addr == RA_CNT_LO));
        sc_wr     = wr_any && (bus_addr == RA_CSC);
        sc_rd     = rd_any && (bus_addr == RA_CSC);
        cmp_hi_wr = wr_any && (bus_addr == RA_CMP_HI);
        cmp_lo_wr = wr_any && (bus_addr == RA_CMP_LO);
        match     = tick && !cnt_wr && ((count_q + CNT_W'(1)) == cmp_active);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ps_q  <= '0;
        end else if (tctl_wr) begin
            run_q <= bus_wdata[PS_W];
            ps_q  <= bus_wdata[PS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_q <= '0;
        else if (cnt_wr) count_q <= '0;
        else if (tick)   count_q <= count_q + CNT_W'(1);
    end

    oct_tick_gen #(.PS_W(PS_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (cnt_wr),
        .ps_sel  (ps_q),
        .tick    (tick)
    );

    oct_cmp_buffer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hi      (cmp_hi_wr),
        .wr_lo      (cmp_lo_wr),
        .wdata      (bus_wdata),
        .ctl_wr     (sc_wr),
        .tick       (tick),
        .cmp_active (cmp_active),
        .state      (cb_state)
    );

    oct_chan_ctrl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sc_wr    (sc_wr),
        .sc_rd    (sc_rd),
        .wbits    (bus_wdata[7:2]),
        .match    (match),
        .sc_rdata (sc_rdata),
        .flag     (ch_flag),
        .irq      (irq),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_TCTL:   bus_rdata = DATA_W'({run_q, ps_q});
            RA_CNT_HI: bus_rdata = count_q[CNT_W-1 -: DATA_W];
            RA_CNT_LO: bus_rdata = count_q[DATA_W-1:0];
            RA_CSC:    bus_rdata = DATA_W'(sc_rdata);
            RA_CMP_HI: bus_rdata = cmp_active[CNT_W-1 -: DATA_W];
            RA_CMP_LO: bus_rdata = cmp_active[DATA_W-1:0];
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/oct_timer_checker.sv
`timescale 1ns/1ps
module oct_timer_checker
    import oct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cnt_wr,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cmp_active,
    input cb_state_e        cb_state,
    input logic             sc_wr,
    input logic             match,
    input logic             flag,
    input logic             irq,
    input logic             pin_out
);
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (count == $past(count) + CNT_W'(1)));

    p_cmp_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_active) |-> ($past(tick) && ($past(cb_state) == CB_PENDING)));

    p_cmp_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cb_state == CB_PENDING) && sc_wr && !tick) |=> $stable(cmp_active));

    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(match));

    p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> ($past(sc_wr) && !$past(match)));

    p_pin_on_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_out) |-> $past(match));
endmodule

bind oc_timer_channel oct_timer_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .cnt_wr     (cnt_wr),
    .tick       (tick),
    .count      (count_q),
    .cmp_active (cmp_active),
    .cb_state   (cb_state),
    .sc_wr      (sc_wr),
    .match      (match),
    .flag       (ch_flag),
    .irq        (irq),
    .pin_out    (pin_out)
);

// File: tb/oc_timer_channel_test.sv
`timescale 1ns/1ps
module oc_timer_channel_test;
    import oct_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, pin_out, pin_oe;

    int checks = 0;
    int errors = 0;

    string      exp_tag[$];
    logic [7:0] exp_val[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_timer_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Driver: queue the expected read item, then issue the read
    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        exp_val.push_back(e);
        exp_tag.push_back(tag);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic chk(input string tag, input logic act, input logic e);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare while a read is on the bus
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (bus_sel && bus_rd && exp_val.size() > 0) begin : cmp_blk
                logic [7:0] e;
                string      t;
                e = exp_val.pop_front();
                t = exp_tag.pop_front();
                checks++;
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: read %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(RA_TCTL,   8'h00, "R1 tctl");
        rd(RA_CNT_HI, 8'h00, "R1 cnt hi");
        rd(RA_CNT_LO, 8'h00, "R1 cnt lo");
        rd(RA_CSC,    8'h00, "R1 status");
        rd(RA_CMP_HI, 8'h00, "R1 cmp hi");
        rd(RA_CMP_LO, 8'h00, "R1 cmp lo");
        chk("R1 irq", irq, 1'b0);
        chk("R1 pin", pin_out, 1'b0);
        chk("R1 oe", pin_oe, 1'b0);

        // R2 divide-by-1 run of 10 ticks, then hold
        wr(RA_TCTL, 8'h08);
        idle(8);
        wr(RA_TCTL, 8'h00);
        rd(RA_CNT_LO, 8'd10, "R2 div1 count");
        idle(5);
        rd(RA_CNT_LO, 8'd10, "R2 hold while stopped");
        wr(RA_CNT_LO, 8'h00);
        rd(RA_CNT_LO, 8'h00, "R2 counter clear");
        // R2 divide-by-4: 20 enabled edges give 5 increments
        wr(RA_TCTL, 8'h0A);
        idle(18);
        wr(RA_TCTL, 8'h00);
        rd(RA_CNT_LO, 8'd5, "R2 div4 count");
        wr(RA_CNT_LO, 8'h00);

        // R5 one byte alone does nothing
        wr(RA_CMP_HI, 8'h12);
        wr(RA_TCTL, 8'h08);
        idle(3);
        wr(RA_TCTL, 8'h00);
        rd(RA_CMP_HI, 8'h00, "R5 single byte hi");
        rd(RA_CMP_LO, 8'h00, "R5 single byte lo");
        // R4 second byte arms, held until an increment
        wr(RA_CMP_LO, 8'h34);
        rd(RA_CMP_HI, 8'h00, "R4 pending not active");
        wr(RA_TCTL, 8'h08);
        idle(2);
        wr(RA_TCTL, 8'h00);
        rd(RA_CMP_HI, 8'h12, "R4 transferred hi");
        rd(RA_CMP_LO, 8'h34, "R4 transferred lo");

        // R6 status write while pending discards
        wr(RA_CMP_HI, 8'h00);
        wr(RA_CMP_LO, 8'h08);
        wr(RA_CSC, 8'h00);
        wr(RA_TCTL, 8'h08);
        idle(3);
        wr(RA_TCTL, 8'h00);
        rd(RA_CMP_HI, 8'h12, "R6 old hi kept");
        rd(RA_CMP_LO, 8'h34, "R6 old lo kept");

        // R13 compare write directly followed by status write, prescale 1
        wr(RA_CNT_LO, 8'h00);
        wr(RA_TCTL, 8'h08);
        wr(RA_CMP_HI, 8'h00);
        wr(RA_CMP_LO, 8'h20);
        wr(RA_CSC, 8'h40);
        rd(RA_CMP_HI, 8'h00, "R13 new hi");
        rd(RA_CMP_LO, 8'h20, "R13 new lo");

        // R7/R8 match raises flag and irq
        idle(60);
        chk("R8 irq on flag", irq, 1'b1);
        rd(RA_CSC, 8'hC0, "R7 flag set");
        wr(RA_CSC, 8'h40);
        chk("R9 irq after clear", irq, 1'b0);
        rd(RA_CSC, 8'h40, "R9 cleared");

        // R7 repeat match; R9 clear needs the read first and bit7 = 0
        wr(RA_CNT_LO, 8'h00);
        idle(60);
        wr(RA_CSC, 8'h40);
        rd(RA_CSC, 8'hC0, "R9 write without read keeps flag");
        wr(RA_CSC, 8'hC0);
        rd(RA_CSC, 8'hC0, "R9 writing one keeps flag");
        wr(RA_CSC, 8'h40);
        rd(RA_CSC, 8'h40, "R9 handshake clears");
        chk("R8 irq low", irq, 1'b0);

        // R10 match in the clearing cycle
        wr(RA_CMP_HI, 8'h00);
        wr(RA_CMP_LO, 8'h02);
        idle(4);
        wr(RA_CNT_LO, 8'h00);
        idle(6);
        rd(RA_CSC, 8'hC0, "R10 flag set before collision");
        wr(RA_CNT_LO, 8'h00);
        wr(RA_CSC, 8'h40);
        rd(RA_CSC, 8'hC0, "R10 set wins");
        wr(RA_CSC, 8'h40);
        rd(RA_CSC, 8'h40, "R10 later clear");

        // R11 software-only mode and reserved bits
        wr(RA_CSC, 8'h50);
        rd(RA_CSC, 8'h50, "R11 mode readback");
        chk("R11 oe off", pin_oe, 1'b0);
        chk("R11 pin idle", pin_out, 1'b0);
        chk("R11 irq idle", irq, 1'b0);
        wr(RA_CSC, 8'h5F);
        rd(RA_CSC, 8'h5C, "R11 reserved read zero");
        chk("R12 oe on", pin_oe, 1'b1);

        // R12 pin actions
        wr(RA_CSC, 8'h54);
        wr(RA_TCTL, 8'h00);
        wr(RA_CNT_LO, 8'h00);
        wr(RA_TCTL, 8'h08);
        idle(6);
        wr(RA_TCTL, 8'h00);
        chk("R12 toggle to 1", pin_out, 1'b1);
        wr(RA_CSC, 8'h58);
        wr(RA_CNT_LO, 8'h00);
        wr(RA_TCTL, 8'h08);
        idle(6);
        wr(RA_TCTL, 8'h00);
        chk("R12 clear", pin_out, 1'b0);
        wr(RA_CSC, 8'h5C);
        wr(RA_CNT_LO, 8'h00);
        wr(RA_TCTL, 8'h08);
        idle(6);
        wr(RA_TCTL, 8'h00);
        chk("R12 set", pin_out, 1'b1);
        wr(RA_CSC, 8'h54);
        wr(RA_CNT_LO, 8'h00);
        wr(RA_TCTL, 8'h08);
        idle(6);
        wr(RA_TCTL, 8'h00);
        chk("R12 toggle to 0", pin_out, 1'b0);

        // R3 wrap with compare value 0
        wr(RA_CSC, 8'h40);
        rd(RA_CSC, 8'hC0, "R3 prep flag");
        wr(RA_CSC, 8'h40);
        wr(RA_CMP_HI, 8'h00);
        wr(RA_CMP_LO, 8'h00);
        wr(RA_TCTL, 8'h08);
        wr(RA_CNT_LO, 8'h00);
        idle(1000);
        chk("R3 no match before wrap", irq, 1'b0);
        idle(64540);
        chk("R3 match on wrap", irq, 1'b1);
        rd(RA_CNT_HI, 8'h00, "R3 counter wrapped");

        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule